// File: doc/BRIEF.md
# Delay-Slot Result Scheduler

This block sits between instruction issue and the register file of a pipelined datapath. Each issued instruction brings a class code, the index of the functional unit it runs on, a destination register index and an already computed result value. The scheduler holds that result for as many delay slots as the class needs and then presents it on one of two register-file write ports. A branch never writes a register. Instead it raises a one-cycle taken pulse that carries its target once its delay slots have gone by.

The scheduler also counts how long each functional unit stays occupied. Most classes free their unit after one cycle, but a double-precision multiply holds its unit for several cycles. An issue to a unit that is still occupied is dropped and flagged. An issue is also dropped when the write-back slot it would land in already holds two results, and when its class code is reserved. When two results retire in the same cycle to the same register, the later-issued one is written and a collision flag is raised.

Top module: `delay_slot_sched`

## Requirements
- R1: While reset is applied, and after it is released with no issue, both write enables, the busy vector, the taken pulse and the reject flag are all low.
- R2: A class-0 (single-cycle) instruction accepted at clock edge E0 shows its destination and value on a write port in the cycle after E0, for exactly one cycle.
- R3: A class-1 (multiply) result appears one cycle later than a class-0 result. A class-2 (load) result appears four cycles later than a class-0 result.
- R4: A class-4 (double-precision multiply) result appears nine cycles later than a class-0 result.
- R5: A class-3 (branch) instruction never asserts a write enable. It raises `br_taken` for one cycle, five cycles later than a class-0 result would appear, with `br_target` equal to the value issued with it.
- R6: A class-4 instruction holds `unit_busy` high for its unit in the three cycles after it is accepted, so the unit is occupied for four cycles in all. Other classes never raise `unit_busy`.
- R7: An issue to a unit whose busy bit is high is dropped. `iss_reject` is high in the cycle after the issue edge, and no write for it ever appears. Issues to other units still proceed.
- R8: Two results retiring in the same cycle to different registers appear together. Port 0 carries the earlier-issued result and port 1 the later-issued one.
- R9: Two results retiring in the same cycle to the same register assert only port 1, which carries the later-issued value, and `wb_collide` is high in that cycle.
- R10: An instruction that writes a register and would retire in a cycle that already holds two results is dropped, with `iss_reject` raised. The two results already held still retire unchanged.
- R11: Reserved class codes 5, 6 and 7 are dropped and flag `iss_reject`. They never cause a write or a taken pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_class | input | 3 | Class code: 0 single, 1 multiply, 2 load, 3 branch, 4 double multiply |
| iss_unit | input | UNIT_W | Functional unit the instruction occupies |
| iss_dst | input | REG_AW | Destination register index |
| iss_data | input | DATA_W | Result value, or branch target for class 3 |
| unit_busy | output | NUM_UNITS | One bit per unit, high while the unit is still occupied |
| iss_reject | output | 1 | The issue at the previous edge was dropped |
| wb0_en | output | 1 | Write port 0 enable |
| wb0_addr | output | REG_AW | Write port 0 register index |
| wb0_data | output | DATA_W | Write port 0 value |
| wb1_en | output | 1 | Write port 1 enable |
| wb1_addr | output | REG_AW | Write port 1 register index |
| wb1_data | output | DATA_W | Write port 1 value |
| wb_collide | output | 1 | Two retiring results named the same register |
| br_taken | output | 1 | A branch's delay slots have elapsed |
| br_target | output | DATA_W | Target of the retiring branch |

## Verification
The bench builds the block with its default parameters: four units, 32-bit values, 32 registers, delay depths of 1, 4, 5 and 9 and a four-cycle double-multiply occupancy. The nine-slot double multiply makes the write-back array ten slots deep. That depth is enough for a load and a multiply issued three cycles apart to meet in one retire slot, and for a later single-cycle issue to find that slot full. With four units, one unit can be held by a double multiply while neighbouring units keep issuing, so the test can show that a busy unit rejects only its own issues.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_MUL    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_BRANCH = 3'd3,
    CLS_DMUL   = 3'd4
  } dss_class_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dss_unit_busy.sv
module dss_unit_busy #(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2,
  parameter int HOLD_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_en,
  input  logic [UNIT_W-1:0]    take_unit,
  input  logic [HOLD_W-1:0]    take_hold,
  output logic [NUM_UNITS-1:0] busy
);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [HOLD_W-1:0] cnt_r;
    logic [HOLD_W-1:0] cnt_n;
    logic              cnt_ce;

    always_comb begin
      cnt_n  = cnt_r;
      cnt_ce = 1'b0;
      if (take_en && (take_unit == UNIT_W'(u))) begin
        cnt_n  = take_hold;
        cnt_ce = 1'b1;
      end else if (cnt_r != '0) begin
        cnt_n  = cnt_r - 1'b1;
        cnt_ce = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_r <= '0;
      end else if (cnt_ce) begin
        cnt_r <= cnt_n;
      end
    end

    assign busy[u] = (cnt_r != '0);
  end

endmodule

// File: rtl/dss_wb_pipe.sv
module dss_wb_pipe #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int DEPTH  = 10,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic [POS_W-1:0]  ins_pos,
  input  logic [REG_AW-1:0] ins_dst,
  input  logic [DATA_W-1:0] ins_data,
  output logic              slot_full,
  output logic              wb0_en,
  output logic [REG_AW-1:0] wb0_addr,
  output logic [DATA_W-1:0] wb0_data,
  output logic              wb1_en,
  output logic [REG_AW-1:0] wb1_addr,
  output logic [DATA_W-1:0] wb1_data,
  output logic              wb_collide
);

  // Lane 0 of a slot always fills before lane 1, so lane 1 is the younger entry.
  logic              v0_q [DEPTH];
  logic              v1_q [DEPTH];
  logic [REG_AW-1:0] a0_q [DEPTH];
  logic [REG_AW-1:0] a1_q [DEPTH];
  logic [DATA_W-1:0] d0_q [DEPTH];
  logic [DATA_W-1:0] d1_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              up_v0, up_v1;
    logic [REG_AW-1:0] up_a0, up_a1;
    logic [DATA_W-1:0] up_d0, up_d1;
    logic              hit;
    logic              v0_r, v1_r, v0_n, v1_n;
    logic [REG_AW-1:0] a0_r, a1_r, a0_n, a1_n;
    logic [DATA_W-1:0] d0_r, d1_r, d0_n, d1_n;

    if (i < DEPTH - 1) begin : g_mid
      assign up_v0 = v0_q[i+1];
      assign up_v1 = v1_q[i+1];
      assign up_a0 = a0_q[i+1];
      assign up_a1 = a1_q[i+1];
      assign up_d0 = d0_q[i+1];
      assign up_d1 = d1_q[i+1];
    end else begin : g_top
      assign up_v0 = 1'b0;
      assign up_v1 = 1'b0;
      assign up_a0 = '0;
      assign up_a1 = '0;
      assign up_d0 = '0;
      assign up_d1 = '0;
    end

    assign hit = ins_en && (ins_pos == POS_W'(i));

    always_comb begin
      v0_n = up_v0;
      v1_n = up_v1;
      a0_n = up_a0;
      a1_n = up_a1;
      d0_n = up_d0;
      d1_n = up_d1;
      if (hit) begin
        if (!up_v0) begin
          v0_n = 1'b1;
          a0_n = ins_dst;
          d0_n = ins_data;
        end else begin
          v1_n = 1'b1;
          a1_n = ins_dst;
          d1_n = ins_data;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v0_r <= 1'b0;
        v1_r <= 1'b0;
      end else begin
        v0_r <= v0_n;
        v1_r <= v1_n;
      end
    end

    always_ff @(posedge clk) begin
      if (v0_n) begin
        a0_r <= a0_n;
        d0_r <= d0_n;
      end
      if (v1_n) begin
        a1_r <= a1_n;
        d1_r <= d1_n;
      end
    end

    assign v0_q[i] = v0_r;
    assign v1_q[i] = v1_r;
    assign a0_q[i] = a0_r;
    assign a1_q[i] = a1_r;
    assign d0_q[i] = d0_r;
    assign d1_q[i] = d1_r;
  end

  // The target slot after this edge's shift is the one now sitting one above it.
  always_comb begin
    slot_full = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (ins_pos == POS_W'(i)) slot_full = v0_q[i+1] && v1_q[i+1];
    end
  end

  assign wb_collide = v0_q[0] && v1_q[0] && (a0_q[0] == a1_q[0]);
  assign wb0_en     = v0_q[0] && !wb_collide;
  assign wb0_addr   = a0_q[0];
  assign wb0_data   = d0_q[0];
  assign wb1_en     = v1_q[0];
  assign wb1_addr   = a1_q[0];
  assign wb1_data   = d1_q[0];

endmodule

// File: rtl/dss_branch_line.sv
module dss_branch_line #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic [DATA_W-1:0] ins_target,
  output logic              taken,
  output logic [DATA_W-1:0] target
);

  logic              bv_q [DEPTH];
  logic [DATA_W-1:0] bt_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic              v_r, v_n;
    logic [DATA_W-1:0] t_r, t_n;

    if (i == DEPTH - 1) begin : g_entry
      assign v_n = ins_en;
      assign t_n = ins_target;
    end else begin : g_follow
      assign v_n = bv_q[i+1];
      assign t_n = bt_q[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_r <= 1'b0;
      end else begin
        v_r <= v_n;
      end
    end

    always_ff @(posedge clk) begin
      if (v_n) t_r <= t_n;
    end

    assign bv_q[i] = v_r;
    assign bt_q[i] = t_r;
  end

  assign taken  = bv_q[0];
  assign target = bt_q[0];

endmodule

// File: rtl/delay_slot_sched.sv
module delay_slot_sched
  import dss_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int REG_AW       = 5,
  parameter int NUM_UNITS    = 4,
  parameter int MUL_SLOTS    = 1,
  parameter int LOAD_SLOTS   = 4,
  parameter int BRANCH_SLOTS = 5,
  parameter int DMUL_SLOTS   = 9,
  parameter int DMUL_OCCUPY  = 4,
  localparam int UNIT_W      = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  input  logic [2:0]           iss_class,
  input  logic [UNIT_W-1:0]    iss_unit,
  input  logic [REG_AW-1:0]    iss_dst,
  input  logic [DATA_W-1:0]    iss_data,
  output logic [NUM_UNITS-1:0] unit_busy,
  output logic                 iss_reject,
  output logic                 wb0_en,
  output logic [REG_AW-1:0]    wb0_addr,
  output logic [DATA_W-1:0]    wb0_data,
  output logic                 wb1_en,
  output logic [REG_AW-1:0]    wb1_addr,
  output logic [DATA_W-1:0]    wb1_data,
  output logic                 wb_collide,
  output logic                 br_taken,
  output logic [DATA_W-1:0]    br_target
);

  localparam int MAX_SLOTS = max_of4(0, MUL_SLOTS, LOAD_SLOTS, DMUL_SLOTS);
  localparam int WB_DEPTH  = (MAX_SLOTS < 1) ? 2 : MAX_SLOTS + 1;
  localparam int POS_W     = $clog2(WB_DEPTH);
  localparam int HOLD_W    = (DMUL_OCCUPY > 2) ? $clog2(DMUL_OCCUPY) : 1;
  localparam int BR_DEPTH  = BRANCH_SLOTS + 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_s1_r, rst_s2_r, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_r <= 1'b0;
      rst_s2_r <= 1'b0;
    end else begin
      rst_s1_r <= 1'b1;
      rst_s2_r <= rst_s1_r;
    end
  end

  assign rst_int_n = rst_s2_r;

  // Class decode.
  logic              cls_ok, cls_writes, cls_branch;
  logic [POS_W-1:0]  cls_pos;
  logic [HOLD_W-1:0] cls_hold;

  always_comb begin
    cls_ok     = 1'b1;
    cls_writes = 1'b1;
    cls_branch = 1'b0;
    cls_pos    = '0;
    cls_hold   = '0;
    case (iss_class)
      CLS_ALU:    cls_pos = '0;
      CLS_MUL:    cls_pos = POS_W'(MUL_SLOTS);
      CLS_LOAD:   cls_pos = POS_W'(LOAD_SLOTS);
      CLS_BRANCH: begin
        cls_writes = 1'b0;
        cls_branch = 1'b1;
      end
      CLS_DMUL: begin
        cls_pos  = POS_W'(DMUL_SLOTS);
        cls_hold = HOLD_W'(DMUL_OCCUPY - 1);
      end
      default: begin
        cls_ok     = 1'b0;
        cls_writes = 1'b0;
      end
    endcase
  end

  // Unit lookup.
  logic unit_ok, busy_hit;

  always_comb begin
    unit_ok  = 1'b0;
    busy_hit = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (iss_unit == UNIT_W'(u)) begin
        unit_ok  = 1'b1;
        busy_hit = unit_busy[u];
      end
    end
  end

  // Acceptance.
  logic slot_full, accept, wb_ins, br_ins, reject_n, reject_r;

  assign accept = iss_valid && cls_ok && unit_ok && !busy_hit && !(cls_writes && slot_full);
  assign wb_ins = accept && cls_writes;
  assign br_ins = accept && cls_branch;

  assign reject_n = iss_valid && !accept;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      reject_r <= 1'b0;
    end else begin
      reject_r <= reject_n;
    end
  end

  assign iss_reject = reject_r;

  dss_unit_busy #(
    .NUM_UNITS (NUM_UNITS),
    .UNIT_W    (UNIT_W),
    .HOLD_W    (HOLD_W)
  ) busy_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .take_en   (accept),
    .take_unit (iss_unit),
    .take_hold (cls_hold),
    .busy      (unit_busy)
  );

  dss_wb_pipe #(
    .DATA_W (DATA_W),
    .REG_AW (REG_AW),
    .DEPTH  (WB_DEPTH),
    .POS_W  (POS_W)
  ) wb_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ins_en     (wb_ins),
    .ins_pos    (cls_pos),
    .ins_dst    (iss_dst),
    .ins_data   (iss_data),
    .slot_full  (slot_full),
    .wb0_en     (wb0_en),
    .wb0_addr   (wb0_addr),
    .wb0_data   (wb0_data),
    .wb1_en     (wb1_en),
    .wb1_addr   (wb1_addr),
    .wb1_data   (wb1_data),
    .wb_collide (wb_collide)
  );

  dss_branch_line #(
    .DATA_W (DATA_W),
    .DEPTH  (BR_DEPTH)
  ) br_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ins_en     (br_ins),
    .ins_target (iss_data),
    .taken      (br_taken),
    .target     (br_target)
  );

endmodule

// File: rtl/dss_sched_checks.sv
module dss_sched_checks #(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 iss_valid,
  input logic [2:0]           iss_class,
  input logic [UNIT_W-1:0]    iss_unit,
  input logic [NUM_UNITS-1:0] unit_busy,
  input logic                 iss_reject,
  input logic                 wb0_en,
  input logic                 wb1_en,
  input logic                 wb_collide
);

  logic sel_busy;

  always_comb begin
    sel_busy = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (iss_unit == UNIT_W'(u)) sel_busy = unit_busy[u];
    end
  end

  assert_alu_retires_or_rejects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class == 3'd0) |=> (wb0_en || wb1_en || iss_reject));

  assert_busy_from_dmul_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((unit_busy != '0) && ($past(unit_busy) == '0)) |-> $past(iss_valid && iss_class == 3'd4));

  assert_busy_unit_rejects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && sel_busy) |=> iss_reject);

  assert_port1_alone_means_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb1_en && !wb0_en) |-> wb_collide);

  assert_collide_keeps_younger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_collide |-> (wb1_en && !wb0_en));

  assert_reserved_class_rejects_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class > 3'd4) |=> iss_reject);

endmodule

bind delay_slot_sched dss_sched_checks #(
  .NUM_UNITS (NUM_UNITS),
  .UNIT_W    (UNIT_W)
) checks_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_class  (iss_class),
  .iss_unit   (iss_unit),
  .unit_busy  (unit_busy),
  .iss_reject (iss_reject),
  .wb0_en     (wb0_en),
  .wb1_en     (wb1_en),
  .wb_collide (wb_collide)
);

// File: tb/delay_slot_sched_tb_top.sv
module delay_slot_sched_tb_top;

  localparam int DW = 32;
  localparam int AW = 5;
  localparam int NU = 4;
  localparam int UW = 2;

  logic          clk;
  logic          rst_n;
  logic          iss_valid;
  logic [2:0]    iss_class;
  logic [UW-1:0] iss_unit;
  logic [AW-1:0] iss_dst;
  logic [DW-1:0] iss_data;
  logic [NU-1:0] unit_busy;
  logic          iss_reject;
  logic          wb0_en, wb1_en, wb_collide, br_taken;
  logic [AW-1:0] wb0_addr, wb1_addr;
  logic [DW-1:0] wb0_data, wb1_data, br_target;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  delay_slot_sched dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_class  (iss_class),
    .iss_unit   (iss_unit),
    .iss_dst    (iss_dst),
    .iss_data   (iss_data),
    .unit_busy  (unit_busy),
    .iss_reject (iss_reject),
    .wb0_en     (wb0_en),
    .wb0_addr   (wb0_addr),
    .wb0_data   (wb0_data),
    .wb1_en     (wb1_en),
    .wb1_addr   (wb1_addr),
    .wb1_data   (wb1_data),
    .wb_collide (wb_collide),
    .br_taken   (br_taken),
    .br_target  (br_target)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one issue for one edge; returns in the cycle after that edge.
  task automatic issue(input logic [2:0] cls, input logic [UW-1:0] unit,
                       input logic [AW-1:0] dst, input logic [DW-1:0] data);
    iss_valid = 1'b1;
    iss_class = cls;
    iss_unit  = unit;
    iss_dst   = dst;
    iss_data  = data;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "wb0_en", 64'(wb0_en), 64'd0);
    chk("R1", "wb1_en", 64'(wb1_en), 64'd0);
    chk("R1", "unit_busy", 64'(unit_busy), 64'd0);
    chk("R1", "br_taken", 64'(br_taken), 64'd0);
    chk("R1", "iss_reject", 64'(iss_reject), 64'd0);
  endtask

  task automatic t_single();
    issue(3'd0, 2'd0, 5'd3, 32'hA5);
    chk("R2", "wb0_en", 64'(wb0_en), 64'd1);
    chk("R2", "wb0_addr", 64'(wb0_addr), 64'd3);
    chk("R2", "wb0_data", 64'(wb0_data), 64'hA5);
    chk("R2", "iss_reject", 64'(iss_reject), 64'd0);
    tick(1);
    chk("R2", "wb0_en after one cycle", 64'(wb0_en), 64'd0);
    tick(10);
  endtask

  task automatic t_mul_load();
    issue(3'd1, 2'd1, 5'd4, 32'h11);
    chk("R3", "mul early wb0_en", 64'(wb0_en), 64'd0);
    chk("R6", "mul busy", 64'(unit_busy), 64'd0);
    tick(1);
    chk("R3", "mul wb0_en", 64'(wb0_en), 64'd1);
    chk("R3", "mul wb0_data", 64'(wb0_data), 64'h11);
    tick(10);
    issue(3'd2, 2'd0, 5'd5, 32'h22);
    tick(3);
    chk("R3", "load early wb0_en", 64'(wb0_en), 64'd0);
    tick(1);
    chk("R3", "load wb0_en", 64'(wb0_en), 64'd1);
    chk("R3", "load wb0_addr", 64'(wb0_addr), 64'd5);
    chk("R3", "load wb0_data", 64'(wb0_data), 64'h22);
    tick(10);
  endtask

  task automatic t_dmul();
    issue(3'd4, 2'd2, 5'd6, 32'h33);
    chk("R6", "dmul busy after E0", 64'(unit_busy), 64'b0100);
    tick(2);
    chk("R6", "dmul busy after E2", 64'(unit_busy), 64'b0100);
    tick(1);
    chk("R6", "dmul busy after E3", 64'(unit_busy), 64'd0);
    tick(5);
    chk("R4", "dmul early wb0_en", 64'(wb0_en), 64'd0);
    tick(1);
    chk("R4", "dmul wb0_en", 64'(wb0_en), 64'd1);
    chk("R4", "dmul wb0_addr", 64'(wb0_addr), 64'd6);
    chk("R4", "dmul wb0_data", 64'(wb0_data), 64'h33);
    tick(10);
  endtask

  task automatic t_busy_conflict();
    issue(3'd4, 2'd3, 5'd7, 32'h44);
    issue(3'd0, 2'd3, 5'd8, 32'h55);
    chk("R7", "reject to busy unit", 64'(iss_reject), 64'd1);
    chk("R7", "no write for dropped", 64'(wb0_en), 64'd0);
    issue(3'd0, 2'd1, 5'd9, 32'h66);
    chk("R7", "other unit accepted", 64'(iss_reject), 64'd0);
    chk("R7", "other unit writes", 64'(wb0_addr), 64'd9);
    tick(1);
    issue(3'd0, 2'd3, 5'd10, 32'h77);
    chk("R7", "unit free again", 64'(iss_reject), 64'd0);
    chk("R7", "freed unit writes", 64'(wb0_addr), 64'd10);
    tick(5);
    chk("R7", "dmul still retires", 64'(wb0_data), 64'h44);
    chk("R7", "dmul addr", 64'(wb0_addr), 64'd7);
    tick(10);
  endtask

  task automatic t_branch();
    issue(3'd3, 2'd0, 5'd1, 32'h1234);
    chk("R5", "no early taken", 64'(br_taken), 64'd0);
    chk("R5", "no write", 64'(wb0_en), 64'd0);
    tick(4);
    chk("R5", "taken not yet", 64'(br_taken), 64'd0);
    tick(1);
    chk("R5", "taken", 64'(br_taken), 64'd1);
    chk("R5", "target", 64'(br_target), 64'h1234);
    chk("R5", "no write at taken", 64'(wb0_en | wb1_en), 64'd0);
    tick(1);
    chk("R5", "taken one cycle", 64'(br_taken), 64'd0);
    tick(10);
  endtask

  task automatic t_dual();
    issue(3'd2, 2'd0, 5'd12, 32'hA1);
    tick(2);
    issue(3'd1, 2'd1, 5'd13, 32'hB2);
    tick(1);
    chk("R8", "port0 en", 64'(wb0_en), 64'd1);
    chk("R8", "port0 older addr", 64'(wb0_addr), 64'd12);
    chk("R8", "port0 older data", 64'(wb0_data), 64'hA1);
    chk("R8", "port1 en", 64'(wb1_en), 64'd1);
    chk("R8", "port1 younger addr", 64'(wb1_addr), 64'd13);
    chk("R8", "port1 younger data", 64'(wb1_data), 64'hB2);
    chk("R8", "no collide", 64'(wb_collide), 64'd0);
    tick(10);
  endtask

  task automatic t_collide();
    issue(3'd2, 2'd0, 5'd14, 32'hC1);
    tick(2);
    issue(3'd1, 2'd1, 5'd14, 32'hC2);
    tick(1);
    chk("R9", "port0 suppressed", 64'(wb0_en), 64'd0);
    chk("R9", "port1 en", 64'(wb1_en), 64'd1);
    chk("R9", "port1 addr", 64'(wb1_addr), 64'd14);
    chk("R9", "younger wins", 64'(wb1_data), 64'hC2);
    chk("R9", "collide flag", 64'(wb_collide), 64'd1);
    tick(1);
    chk("R9", "collide one cycle", 64'(wb_collide), 64'd0);
    tick(10);
  endtask

  task automatic t_slot_full();
    issue(3'd2, 2'd0, 5'd15, 32'hD1);
    tick(2);
    issue(3'd1, 2'd1, 5'd16, 32'hD2);
    issue(3'd0, 2'd2, 5'd17, 32'hD3);
    chk("R10", "third rejected", 64'(iss_reject), 64'd1);
    chk("R10", "port0 kept", 64'(wb0_addr), 64'd15);
    chk("R10", "port1 kept", 64'(wb1_addr), 64'd16);
    chk("R10", "both en", 64'(wb0_en & wb1_en), 64'd1);
    tick(1);
    chk("R10", "dropped never written", 64'(wb0_en | wb1_en), 64'd0);
    tick(10);
  endtask

  task automatic t_reserved();
    for (int c = 5; c < 8; c++) begin
      issue(3'(c), 2'd0, 5'd18, 32'h99);
      chk("R11", "reserved reject", 64'(iss_reject), 64'd1);
    end
    for (int k = 0; k < 10; k++) begin
      chk("R11", "no write or taken", 64'(wb0_en | wb1_en | br_taken), 64'd0);
      tick(1);
    end
    chk("R11", "reject clears", 64'(iss_reject), 64'd0);
  endtask

  initial begin
    rst_n     = 1'b0;
    iss_valid = 1'b0;
    iss_class = '0;
    iss_unit  = '0;
    iss_dst   = '0;
    iss_data  = '0;
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_single();
    t_mul_load();
    t_dmul();
    t_busy_conflict();
    t_branch();
    t_dual();
    t_collide();
    t_slot_full();
    t_reserved();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule